// File: doc/BRIEF.md
# LIN Transceiver Mode and Fail-Safe Controller

This block is the digital control logic that sits beside a LIN physical layer. From the system power mode code, a standby-control bit and a battery-undervoltage-recovered flag it chooses one of three transceiver states: Active (transmit and receive), Lowpower (watching the bus for a remote wake-up) or Off (fully quiet). The analog driver, slew shaping and comparators stay outside. They appear here only as a digital driver command and a digital bus-state input.

In Active state the transmit data from the protocol controller is passed to the bus driver, and the sampled bus state is returned on the receive output. A recessive bus gives a high receive level and a dominant bus gives a low one. A fail-safe timer limits how long a stuck-low transmit input can hold the bus dominant. In Lowpower state a wake filter accepts a remote wake-up only after the bus has stayed dominant without a break for a minimum time. A detected wake-up sets a sticky flag that software clears with a pulse. The transmit and bus inputs are asynchronous and pass through two-flop synchronizers first. All times are counted in system clock cycles. A transmit pin left floating is expected to be pulled high at the pad, so it reads as recessive.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, mode_out is 2'b00 (Off), drv_tx is 1 (recessive), rxd_out is 1 and wake_flag is 0.
- R2: mode_out becomes 2'b10 (Active) one clock after sys_mode[1] is 1, stby_ctl is 0 and bat_ok is 1 are sampled together.
- R3: mode_out becomes 2'b01 (Lowpower) one clock after stby_ctl is sampled as 1, whatever sys_mode and bat_ok are.
- R4: mode_out becomes 2'b00 (Off) one clock after stby_ctl is 0 and sys_mode[1] is 0 are sampled.
- R5: With sys_mode[1] at 1, stby_ctl at 0 and bat_ok at 0, mode_out is 2'b00, drv_tx stays 1 and rxd_out stays 1, even if the bus and txd_in are low.
- R6: In Active state rxd_out equals bus_in (1 = recessive, 0 = dominant) two clocks after bus_in changes. In every other state rxd_out is 1.
- R7: In Active state drv_tx equals txd_in (0 = drive dominant) two clocks after txd_in changes, as long as no timeout has occurred. In every other state drv_tx is 1.
- R8: A low period of txd_in drives drv_tx low for at most TXD_TO clocks. After that drv_tx stays 1 until txd_in returns high, and the next falling edge enables driving again.
- R9: In Lowpower state wake_flag rises once bus_in has been dominant for WAKE_MIN consecutive sampled clocks, that is, WAKE_MIN+2 clocks after bus_in falls. A dominant pulse shorter than WAKE_MIN clocks leaves wake_flag at 0.
- R10: wake_flag stays 1 until wake_clr is pulsed. It reads 0 one clock after the pulse.
- R11: A dominant bus of any length in Off or Active state never sets wake_flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_mode | input | 2 | System power mode code; bit 1 set means a normal running mode |
| stby_ctl | input | 1 | Transceiver standby request (1 = Lowpower with wake detection) |
| bat_ok | input | 1 | Battery above the undervoltage recovery level |
| txd_in | input | 1 | Transmit data from the protocol controller, asynchronous (0 = dominant) |
| bus_in | input | 1 | Bus level from the receiver comparator, asynchronous (0 = dominant) |
| wake_clr | input | 1 | One-clock pulse that clears the wake flag |
| drv_tx | output | 1 | Bus driver command (0 = drive dominant, 1 = recessive) |
| rxd_out | output | 1 | Received data to the protocol controller (0 = dominant) |
| wake_flag | output | 1 | Sticky remote wake-up indication |
| mode_out | output | 2 | Transceiver state: 00 Off, 01 Lowpower, 10 Active |

## Verification
The hardest cases to reach are the limits of the two cycle-counting filters. Either a dominant bus pulse ends exactly one clock short of the wake threshold, or the transmit input stays low long enough for the timeout to cut the driver. The stimulus gets there with directed low periods of exact length, timed against the two-stage synchronizer. It also sends random dominant pulses that are always shorter than the wake minimum, with recessive gaps between them. The bench counts the clocks the driver spends dominant and checks the count against the timeout, and it reads the wake flag one clock before and in the clock of its expected rise.

// File: rtl/lin_mode_pkg.sv
// Package: shared transceiver state encoding for the LIN mode controller.
// Assumes the two-bit encoding below is decoded by the analog power switches.
package lin_mode_pkg;
    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_LOWPWR = 2'b01,
        MODE_ACTIVE = 2'b10
    } lin_mode_e;
endpackage

// File: rtl/lin_sync2.sv
// Module: two-flop synchronizer for one asynchronous level input.
// Assumes the input is a slow level. RST_VAL gives the reset level, which is
// the recessive level for LIN signals.
module lin_sync2 #(
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic meta_q;

    // Two-stage capture of the asynchronous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/lin_wake_filter.sv
// Module: remote wake-up filter with a sticky flag.
// It counts consecutive dominant samples while enabled and raises the flag
// after WAKE_MIN of them. A recessive sample or disable restarts the count.
// Assumes bus_rec is already synchronized (1 = recessive).
module lin_wake_filter #(
    parameter int WAKE_MIN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bus_rec,
    input  logic clr,
    output logic flag
);
    localparam int CNT_W = (WAKE_MIN > 1) ? $clog2(WAKE_MIN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_MIN - 1);

    logic [CNT_W-1:0] dom_cnt;
    logic             hit;

    // Threshold reached on this dominant sample.
    always_comb hit = en && !bus_rec && (dom_cnt == CNT_LAST);

    // Consecutive dominant sample counter, held once the threshold is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || bus_rec) begin
            dom_cnt <= '0;
        end else if (dom_cnt != CNT_LAST) begin
            dom_cnt <= dom_cnt + 1'b1;
        end
    end

    // Sticky flag: a new detection wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    // R10: flag holds without a clear.
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    // R9: the flag only rises after a dominant sample.
    p_wake_after_dom_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> !$past(bus_rec));
endmodule

// File: rtl/lin_txd_guard.sv
// Module: transmit dominant timeout.
// It counts the clocks the synchronized transmit input stays low. After TXD_TO
// of them it blocks the driver until the input returns high, so the next
// falling edge starts a new window. Assumes txd_s is synchronized.
module lin_txd_guard #(
    parameter int TXD_TO = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_s,
    output logic blocked
);
    localparam int CNT_W = (TXD_TO > 1) ? $clog2(TXD_TO) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TXD_TO - 1);

    logic [CNT_W-1:0] lo_cnt;

    // Low-time counter; restarts whenever the input is high.
    always_ff @(posedge clk) begin
        if (!rst_n || txd_s) begin
            lo_cnt <= '0;
        end else if (!blocked && lo_cnt != CNT_LAST) begin
            lo_cnt <= lo_cnt + 1'b1;
        end
    end

    // Block flag: set at the end of the window, released by a high input.
    always_ff @(posedge clk) begin
        if (!rst_n || txd_s) begin
            blocked <= 1'b0;
        end else if (lo_cnt == CNT_LAST) begin
            blocked <= 1'b1;
        end
    end

    // R8: a high transmit level releases the block.
    p_release_on_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && txd_s) |=> !blocked);
    // R8: the block only starts while the input is low.
    p_block_needs_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blocked) |-> !$past(txd_s));
endmodule

// File: rtl/lin_mode_ctrl.sv
// Module: LIN transceiver mode and fail-safe controller (top).
// It decodes the transceiver state from the mode code, the standby bit and
// the battery flag, and gates the transmit and receive paths. It instantiates
// the synchronizers, the wake filter and the transmit timeout guard.
// Assumes the control inputs are synchronous to clk. txd_in and bus_in are
// asynchronous, and a floating txd_in is pulled high at the pad.
module lin_mode_ctrl
    import lin_mode_pkg::*;
#(
    parameter int WAKE_MIN = 16,
    parameter int TXD_TO   = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sys_mode,
    input  logic       stby_ctl,
    input  logic       bat_ok,
    input  logic       txd_in,
    input  logic       bus_in,
    input  logic       wake_clr,
    output logic       drv_tx,
    output logic       rxd_out,
    output logic       wake_flag,
    output logic [1:0] mode_out
);
    lin_mode_e mode_q;
    lin_mode_e mode_nxt;
    logic      txd_s;
    logic      bus_s;
    logic      tx_blocked;
    logic      is_active;

    // Input synchronizers, both reset to the recessive level.
    lin_sync2 #(.RST_VAL(1'b1)) u_sync_txd (
        .clk(clk), .rst_n(rst_n), .d_async(txd_in), .q_sync(txd_s));
    lin_sync2 #(.RST_VAL(1'b1)) u_sync_bus (
        .clk(clk), .rst_n(rst_n), .d_async(bus_in), .q_sync(bus_s));

    // State decode: standby first, then the normal-and-powered check.
    always_comb begin
        if (stby_ctl)                  mode_nxt = MODE_LOWPWR;
        else if (sys_mode[1] && bat_ok) mode_nxt = MODE_ACTIVE;
        else                           mode_nxt = MODE_OFF;
    end

    // Registered transceiver state.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_OFF;
        else        mode_q <= mode_nxt;
    end

    lin_wake_filter #(.WAKE_MIN(WAKE_MIN)) u_wake (
        .clk(clk), .rst_n(rst_n), .en(mode_q == MODE_LOWPWR),
        .bus_rec(bus_s), .clr(wake_clr), .flag(wake_flag));

    lin_txd_guard #(.TXD_TO(TXD_TO)) u_guard (
        .clk(clk), .rst_n(rst_n), .txd_s(txd_s), .blocked(tx_blocked));

    // Output gating: the paths are open only in Active state.
    always_comb begin
        is_active = (mode_q == MODE_ACTIVE);
        drv_tx    = !(is_active && !tx_blocked && !txd_s);
        rxd_out   = is_active ? bus_s : 1'b1;
        mode_out  = mode_q;
    end

    // R11: a wake-up only comes out of the Lowpower state.
    p_wake_only_lowpwr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> ($past(mode_q) == MODE_LOWPWR));
    // R2: Active only follows a powered, non-standby request.
    p_active_needs_bat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ACTIVE) |-> ($past(bat_ok) && !$past(stby_ctl)));
    // R8: the driver is never dominant while the guard blocks it.
    p_no_drive_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_blocked |-> drv_tx);
endmodule

// File: tb/lin_mode_ctrl_test.sv
// Bench: directed corner cases mixed with seeded random stimulus for the LIN
// mode controller. Inputs change on falling edges and outputs are sampled on
// falling edges.
module lin_mode_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WAKE_MIN   = 16;
    localparam int TXD_TO     = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sys_mode = 2'b00;
    logic       stby_ctl = 1'b0;
    logic       bat_ok = 1'b0;
    logic       txd_in = 1'b1;
    logic       bus_in = 1'b1;
    logic       wake_clr = 1'b0;
    logic       drv_tx, rxd_out, wake_flag;
    logic [1:0] mode_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    lin_mode_ctrl #(.WAKE_MIN(WAKE_MIN), .TXD_TO(TXD_TO)) uut (
        .clk(clk), .rst_n(rst_n), .sys_mode(sys_mode), .stby_ctl(stby_ctl),
        .bat_ok(bat_ok), .txd_in(txd_in), .bus_in(bus_in), .wake_clr(wake_clr),
        .drv_tx(drv_tx), .rxd_out(rxd_out), .wake_flag(wake_flag),
        .mode_out(mode_out));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [1:0] exp_mode(logic [1:0] sm, logic st, logic bt);
        if (st)              return 2'b01;
        else if (sm[1] && bt) return 2'b10;
        else                 return 2'b00;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_mode(logic [1:0] sm, logic st, logic bt);
        sys_mode = sm; stby_ctl = st; bat_ok = bt;
        tick(1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        int dom_cycles;
        seed = $urandom(32'h1A5C);
        // R1: reset state
        tick(3);
        check("R1 mode", {2'b0, mode_out}, 4'h0);
        check("R1 drv/rxd/wake", {1'b0, drv_tx, rxd_out, wake_flag}, 4'b0110);
        rst_n = 1'b1;
        tick(1);
        check("R1 after release", {drv_tx, rxd_out, wake_flag, mode_out[0]}, 4'b1100);

        // R2 R3 R4: random mode decode
        for (int i = 0; i < 60; i++) begin
            logic [1:0] sm;
            logic st, bt;
            sm = 2'($urandom); st = 1'($urandom); bt = 1'($urandom);
            set_mode(sm, st, bt);
            if (st) check("R3 decode", {2'b0, mode_out}, {2'b0, exp_mode(sm, st, bt)});
            else if (sm[1] && bt) check("R2 decode", {2'b0, mode_out}, {2'b0, exp_mode(sm, st, bt)});
            else check("R4 decode", {2'b0, mode_out}, {2'b0, exp_mode(sm, st, bt)});
        end

        // R5: normal mode with undervoltage keeps the paths quiet
        set_mode(2'b11, 1'b0, 1'b0);
        bus_in = 1'b0; txd_in = 1'b0;
        tick(3);
        check("R5 mode", {2'b0, mode_out}, 4'h0);
        check("R5 drv/rxd", {2'b0, drv_tx, rxd_out}, 4'b0011);
        bus_in = 1'b1; txd_in = 1'b1;
        tick(3);

        // R6 R7: Active paths follow inputs after two clocks
        set_mode(2'b10, 1'b0, 1'b1);
        for (int i = 0; i < 40; i++) begin
            bus_in = 1'($urandom);
            txd_in = (i % 5 == 4) ? 1'b1 : 1'($urandom);
            tick(2);
            check("R6 rxd follows bus", {3'b0, rxd_out}, {3'b0, bus_in});
            check("R7 drv follows txd", {3'b0, drv_tx}, {3'b0, txd_in});
        end
        txd_in = 1'b1; bus_in = 1'b0;
        tick(3);
        // R6: not Active gives a high receive level
        set_mode(2'b10, 1'b1, 1'b1);
        check("R6 rxd high in lowpower", {3'b0, rxd_out}, 4'h1);
        bus_in = 1'b1;
        tick(3);
        wake_clr = 1'b1; tick(1); wake_clr = 1'b0;

        // R7: not Active keeps the driver recessive
        set_mode(2'b01, 1'b0, 1'b1);
        txd_in = 1'b0;
        tick(3);
        check("R7 drv recessive in off", {3'b0, drv_tx}, 4'h1);
        txd_in = 1'b1;
        tick(3);

        // R8: dominant timeout
        set_mode(2'b11, 1'b0, 1'b1);
        tick(2);
        txd_in = 1'b0;
        dom_cycles = 0;
        for (int i = 0; i < TXD_TO + 12; i++) begin
            tick(1);
            if (!drv_tx) dom_cycles++;
        end
        check("R8 dominant clocks", 4'(dom_cycles == TXD_TO), 4'h1);
        check("R8 still blocked", {3'b0, drv_tx}, 4'h1);
        txd_in = 1'b1; tick(3);
        txd_in = 1'b0; tick(2);
        check("R8 re-enabled after new fall", {3'b0, drv_tx}, 4'h0);
        txd_in = 1'b1; tick(3);

        // R11: no wake in Active or Off
        bus_in = 1'b0; tick(2 * WAKE_MIN + 4);
        check("R11 no wake in active", {3'b0, wake_flag}, 4'h0);
        set_mode(2'b00, 1'b0, 1'b1);
        tick(2 * WAKE_MIN + 4);
        check("R11 no wake in off", {3'b0, wake_flag}, 4'h0);
        bus_in = 1'b1; tick(3);

        // R9: short pulses in Lowpower are ignored
        set_mode(2'b00, 1'b1, 1'b0);
        bus_in = 1'b0; tick(WAKE_MIN - 1);
        bus_in = 1'b1; tick(4);
        check("R9 pulse one short", {3'b0, wake_flag}, 4'h0);
        for (int i = 0; i < 10; i++) begin
            bus_in = 1'b0; tick(1 + int'($urandom % (WAKE_MIN - 1)));
            bus_in = 1'b1; tick(3);
            check("R9 random short pulse", {3'b0, wake_flag}, 4'h0);
        end
        // R9: exact threshold
        bus_in = 1'b0;
        tick(WAKE_MIN + 1);
        check("R9 one clock before wake", {3'b0, wake_flag}, 4'h0);
        tick(1);
        check("R9 wake at threshold", {3'b0, wake_flag}, 4'h1);

        // R10: sticky until cleared
        bus_in = 1'b1; tick(4);
        set_mode(2'b10, 1'b0, 1'b1);
        tick(3);
        check("R10 flag sticky", {3'b0, wake_flag}, 4'h1);
        wake_clr = 1'b1; tick(1); wake_clr = 1'b0;
        check("R10 flag cleared", {3'b0, wake_flag}, 4'h0);
        tick(2);
        check("R10 stays clear", {3'b0, wake_flag}, 4'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule